// File: doc/BRIEF.md
# Double-Data-Rate Read Burst Output Driver

This block takes one wide read word, holding a four-word burst, from the memory array. It presents the four words on a double-data-rate output bus, one word per clock phase. It also produces a complementary pair of echo clocks and an output-enable that drives the tri-state control of the data pads.

The block runs on a fast system clock. The slower burst clock pair comes in as sampled levels. A rising edge on the true clock line marks an even phase, and a rising edge on the complement line marks an odd phase. Normally the output clock pair paces the block. When both output clock lines are held high, the input clock pair paces it instead.

A one-deep slot holds a read word until the next even phase, when the burst starts. A second burst can be queued while a burst is running, and it follows with no gap. An optional parameter adds a one-phase delay to the data and enable. This models a data path whose output is not aligned to the clock edge.

Top module: `ddr_burst_out`

## Requirements
- R1: The read word holds beat k in bits [k*W +: W], where W is the word width. A burst emits beat 0 on an even phase, beat 1 on the following odd phase, beat 2 on the next even phase and beat 3 on the next odd phase. The order is never changed.
- R2: An even phase drives echo_p high and echo_n low. An odd phase drives echo_p low and echo_n high. The two echo outputs are always complementary.
- R3: The echo clocks toggle on every phase, including when no read is in progress.
- R4: q_oe is high only during the four phases that carry a burst's beats. Whenever q_oe is low, q is all zeros.
- R5: While reset is asserted and after it is released: q_oe is 0, q is 0, echo_p is 0 and echo_n is 1.
- R6: An accepted rd_vld strobe starts its burst on the first even phase after the strobe. From that phase on, q_oe is 1 and q carries beat 0.
- R7: A rd_vld strobe that arrives while an earlier accepted word is still waiting to start is ignored.
- R8: A strobe accepted while a burst is running starts its burst on the even phase right after that burst's beat 3. q_oe stays high across the boundary. If nothing is waiting, q_oe falls on that even phase.
- R9: While out_ck and out_ckb are both high, the phases come from the in_ck/in_ckb pair.
- R10: With DLL_OFF=1, q and q_oe on each phase equal the values the DLL_OFF=0 build shows on the phase before. The echo clocks are not delayed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock that samples the burst clock levels |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_vld | input | 1 | One-cycle strobe: rd_word holds a new burst |
| rd_word | input | BURST*W | Burst read from the array, beat k in bits [k*W +: W] |
| out_ck | input | 1 | Output clock, true line (sampled level) |
| out_ckb | input | 1 | Output clock, complement line (sampled level) |
| in_ck | input | 1 | Input clock, true line, used as fallback |
| in_ckb | input | 1 | Input clock, complement line, used as fallback |
| q | output | W | Double-data-rate data bus |
| q_oe | output | 1 | Output enable for the data pads (1 = drive, 0 = high impedance) |
| echo_p | output | 1 | Echo clock, true |
| echo_n | output | 1 | Echo clock, complement |

## Verification
A single burst from idle shows that the burst waits for the first even phase and that the beats come out in stored order. Two strobes on adjacent cycles before any even phase separate ignoring the second strobe from overwriting the first: an overwrite would change beat 0. A strobe during a running burst separates a gap-free follow-on burst from one that drops the enable for a phase. A burst with the output pair held high shows that the fallback pair alone can pace the beats and echoes. A second instance with the delay option, compared phase by phase with the first, shows the one-phase lag.

// File: rtl/ddrq_pkg.sv
package ddrq_pkg;
   typedef struct packed {
      logic rise;   // even phase: true line rose
      logic fall;   // odd phase: complement line rose
   } phase_ev_t;
endpackage

// File: rtl/ddrq_clk_pick.sv
module ddrq_clk_pick
   import ddrq_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      out_ck,
   input  logic      out_ckb,
   input  logic      in_ck,
   input  logic      in_ckb,
   output phase_ev_t ev
);
   logic use_in, ck_sel, ckb_sel, ck_q, ckb_q;

   // both output lines parked high selects the input pair
   assign use_in  = out_ck & out_ckb;
   assign ck_sel  = use_in ? in_ck  : out_ck;
   assign ckb_sel = use_in ? in_ckb : out_ckb;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ck_q  <= 1'b0;
         ckb_q <= 1'b0;
      end else begin
         ck_q  <= ck_sel;
         ckb_q <= ckb_sel;
      end
   end

   assign ev.rise = ck_sel  & ~ck_q;
   assign ev.fall = ckb_sel & ~ckb_q;

   // R2: complementary lines never yield both phase kinds at once
   a_r2_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
      !(ev.rise && ev.fall));
endmodule

// File: rtl/ddrq_burst_seq.sv
module ddrq_burst_seq
   import ddrq_pkg::*;
#(
   parameter int W     = 18,
   parameter int BURST = 4
)(
   input  logic               clk,
   input  logic               rst_n,
   input  phase_ev_t          ev,
   input  logic               rd_vld,
   input  logic [BURST*W-1:0] rd_word,
   output logic [W-1:0]       q,
   output logic               oe
);
   localparam int BW   = (BURST > 2) ? $clog2(BURST) : 1;
   localparam int LAST = BURST - 1;

   generate
      if (BURST < 2 || (BURST % 2) != 0) begin : g_bad_burst
         $error("BURST must be even and at least 2");
      end
      if (W < 1) begin : g_bad_w
         $error("W must be positive");
      end
   endgenerate

   logic               pend_v, busy, start, take;
   logic [BURST*W-1:0] pend_w, cur_w;
   logic [BW-1:0]      beat, nxt;

   assign nxt   = beat + 1'b1;
   assign start = ev.rise && pend_v && (!busy || beat == BW'(LAST));
   assign take  = rd_vld && (!pend_v || start);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_v <= 1'b0;
         pend_w <= '0;
         cur_w  <= '0;
         beat   <= '0;
         busy   <= 1'b0;
         q      <= '0;
         oe     <= 1'b0;
      end else begin
         pend_v <= (pend_v & ~start) | take;
         if (take) pend_w <= rd_word;
         if (start) begin
            cur_w <= pend_w;
            beat  <= '0;
            busy  <= 1'b1;
            q     <= pend_w[W-1:0];
            oe    <= 1'b1;
         end else if (ev.rise && busy) begin
            if (beat == BW'(LAST)) begin
               busy <= 1'b0;
               oe   <= 1'b0;
               q    <= '0;
            end else if (beat[0]) begin
               beat <= nxt;
               q    <= cur_w[int'(nxt)*W +: W];
            end
         end else if (ev.fall && busy && !beat[0]) begin
            beat <= nxt;
            q    <= cur_w[int'(nxt)*W +: W];
         end
      end
   end

   // R1: an odd phase after an even beat moves to the odd beat with output on
   a_r1_odd_step: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ev.fall && !beat[0]) |=> (beat[0] && oe));
   // R8: last beat, nothing waiting, next even phase drops the enable
   a_r8_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (ev.rise && busy && beat == BW'(LAST) && !pend_v) |=> !oe);
   // R7: a waiting word is not overwritten by a later strobe
   a_r7_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_v && rd_vld && !start) |=> $stable(pend_w));
endmodule

// File: rtl/ddrq_out_stage.sv
module ddrq_out_stage
   import ddrq_pkg::*;
#(
   parameter int W       = 18,
   parameter bit DLL_OFF = 1'b0
)(
   input  logic         clk,
   input  logic         rst_n,
   input  phase_ev_t    ev,
   input  logic [W-1:0] q_i,
   input  logic         oe_i,
   output logic [W-1:0] q_o,
   output logic         oe_o,
   output logic         echo_p,
   output logic         echo_n
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         echo_p <= 1'b0;
         echo_n <= 1'b1;
      end else if (ev.rise) begin
         echo_p <= 1'b1;
         echo_n <= 1'b0;
      end else if (ev.fall) begin
         echo_p <= 1'b0;
         echo_n <= 1'b1;
      end
   end

   generate
      if (DLL_OFF) begin : g_late
         logic [W-1:0] q_d;
         logic         oe_d;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               q_d  <= '0;
               oe_d <= 1'b0;
            end else if (ev.rise || ev.fall) begin
               q_d  <= q_i;
               oe_d <= oe_i;
            end
         end
         assign q_o  = q_d;
         assign oe_o = oe_d;
      end else begin : g_direct
         assign q_o  = q_i;
         assign oe_o = oe_i;
      end
   endgenerate

   // R2: the echo outputs are separate flops and must stay opposite
   a_r2_echo_compl: assert property (@(posedge clk) disable iff (!rst_n)
      echo_p != echo_n);
   // R3: every phase moves the echo pair, even with no read
   a_r3_echo_even: assert property (@(posedge clk) disable iff (!rst_n)
      ev.rise |=> (echo_p && !echo_n));
   a_r3_echo_odd: assert property (@(posedge clk) disable iff (!rst_n)
      (ev.fall && !ev.rise) |=> (!echo_p && echo_n));
endmodule

// File: rtl/ddr_burst_out.sv
module ddr_burst_out
   import ddrq_pkg::*;
#(
   parameter int W       = 18,
   parameter int BURST   = 4,
   parameter bit DLL_OFF = 1'b0
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rd_vld,
   input  logic [BURST*W-1:0] rd_word,
   input  logic               out_ck,
   input  logic               out_ckb,
   input  logic               in_ck,
   input  logic               in_ckb,
   output logic [W-1:0]       q,
   output logic               q_oe,
   output logic               echo_p,
   output logic               echo_n
);
   phase_ev_t    ev;
   logic [W-1:0] q_s;
   logic         oe_s;

   ddrq_clk_pick u_pick (
      .clk(clk), .rst_n(rst_n), .out_ck(out_ck), .out_ckb(out_ckb),
      .in_ck(in_ck), .in_ckb(in_ckb), .ev(ev));

   ddrq_burst_seq #(.W(W), .BURST(BURST)) u_seq (
      .clk(clk), .rst_n(rst_n), .ev(ev), .rd_vld(rd_vld),
      .rd_word(rd_word), .q(q_s), .oe(oe_s));

   ddrq_out_stage #(.W(W), .DLL_OFF(DLL_OFF)) u_out (
      .clk(clk), .rst_n(rst_n), .ev(ev), .q_i(q_s), .oe_i(oe_s),
      .q_o(q), .oe_o(q_oe), .echo_p(echo_p), .echo_n(echo_n));

   // R4: a disabled bus carries zeros
   a_r4_oe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !q_oe |-> (q == '0));
   // R5: reset leaves the pads disabled
   a_r5_reset_off: assert property (@(posedge clk)
      !rst_n |=> (!q_oe && echo_n));
endmodule

// File: tb/ddr_burst_out_test.sv
`timescale 1ns/1ps
module ddr_burst_out_test;
   localparam int W = 18;
   localparam int BURST = 4;
   localparam int PH_CYC = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rd_vld = 1'b0;
   logic [BURST*W-1:0] rd_word = '0;
   logic out_ck = 1'b0, out_ckb = 1'b1, in_ck = 1'b0, in_ckb = 1'b1;
   logic [W-1:0] q, q_d;
   logic q_oe, q_oe_d, echo_p, echo_n, echo_p_d, echo_n_d;

   always #2 clk = ~clk;

   ddr_burst_out #(.W(W), .BURST(BURST), .DLL_OFF(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .rd_vld(rd_vld), .rd_word(rd_word),
      .out_ck(out_ck), .out_ckb(out_ckb), .in_ck(in_ck), .in_ckb(in_ckb),
      .q(q), .q_oe(q_oe), .echo_p(echo_p), .echo_n(echo_n));

   ddr_burst_out #(.W(W), .BURST(BURST), .DLL_OFF(1'b1)) uut_dly (
      .clk(clk), .rst_n(rst_n), .rd_vld(rd_vld), .rd_word(rd_word),
      .out_ck(out_ck), .out_ckb(out_ckb), .in_ck(in_ck), .in_ckb(in_ckb),
      .q(q_d), .q_oe(q_oe_d), .echo_p(echo_p_d), .echo_n(echo_n_d));

   int checks = 0, errors = 0, ev_cnt = 0;
   logic [W-1:0] expq[$];
   bit fallback = 1'b0, nxt_rise = 1'b1, contig = 1'b0, done = 1'b0;
   logic last_p = 1'b0, last_n = 1'b1, prev_oe = 1'b0;
   logic [W-1:0] prev_q = '0;

   task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                      input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one clock phase; starts and ends at a falling clk edge
   task automatic step_phase();
      if (fallback) begin in_ck = nxt_rise; in_ckb = !nxt_rise; end
      else begin out_ck = nxt_rise; out_ckb = !nxt_rise; end
      nxt_rise = !nxt_rise;
      repeat (PH_CYC) @(negedge clk);
   endtask

   // driver: strobe a word, push expected beats when it must be accepted
   task automatic issue(input logic [BURST*W-1:0] w, input bit accept);
      rd_vld = 1'b1; rd_word = w;
      @(negedge clk);
      rd_vld = 1'b0;
      if (accept) for (int k = 0; k < BURST; k++) expq.push_back(w[k*W +: W]);
   endtask

   function automatic logic [BURST*W-1:0] mk(input int seed);
      logic [BURST*W-1:0] r;
      for (int k = 0; k < BURST; k++) r[k*W +: W] = W'(seed * 16 + k + 1) ^ W'(18'h2A5A5);
      return r;
   endfunction

   // monitor: one comparison set per phase, seen as a change on the echo pair
   always @(negedge clk) begin
      if (rst_n && (echo_p != last_p || echo_n != last_n)) begin
         ev_cnt++;
         chk(echo_n == ~echo_p, "R2 echo complement", W'(echo_n), W'(~echo_p));
         if (q_oe) begin
            if (expq.size() == 0) chk(1'b0, "R4 enable with no burst", q, '0);
            else begin
               logic [W-1:0] e;
               e = expq.pop_front();
               chk(q == e, "R1 beat order", q, e);
               if (expq.size() == 0) contig = 1'b0;
            end
         end else begin
            chk(q == '0, "R4 quiet bus", q, '0);
            if (contig && expq.size() != 0) chk(1'b0, "R8 gap between bursts", W'(q_oe), 1);
         end
         chk(q_d == prev_q && q_oe_d == prev_oe, "R10 delayed copy", q_d, prev_q);
         chk(echo_p_d == echo_p, "R10 echo not delayed", W'(echo_p_d), W'(echo_p));
         prev_q = q; prev_oe = q_oe;
      end
      last_p = echo_p; last_n = echo_n;
   end

   initial begin
      int c0;
      logic [BURST*W-1:0] a, b;
      repeat (4) @(negedge clk);
      chk(q_oe == 0 && q == '0, "R5 reset outputs", q, '0);
      chk(echo_p == 0 && echo_n == 1, "R5 reset echo", W'({echo_p, echo_n}), W'(2'b01));
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // idle echo
      c0 = ev_cnt;
      repeat (6) step_phase();
      chk(ev_cnt - c0 == 6, "R3 echo runs idle", W'(ev_cnt - c0), 6);
      chk(q_oe == 0, "R4 idle disabled", W'(q_oe), 0);

      // single burst, next phase is even
      a = mk(1);
      issue(a, 1'b1);
      step_phase();
      chk(q_oe == 1 && q == a[W-1:0], "R6 start on first even phase", q, a[W-1:0]);
      repeat (5) step_phase();
      chk(q_oe == 0, "R8 enable drops after beat 3", W'(q_oe), 0);

      // two strobes before the even phase: second ignored
      a = mk(2); b = mk(3);
      issue(a, 1'b1);
      issue(b, 1'b0);
      repeat (6) step_phase();
      chk(expq.size() == 0, "R7 second strobe ignored", W'(expq.size()), 0);

      // follow-on burst queued while running
      a = mk(4); b = mk(5);
      issue(a, 1'b1);
      step_phase();
      contig = 1'b1;
      issue(b, 1'b1);
      repeat (3) step_phase();
      step_phase();
      chk(q_oe == 1 && q == b[W-1:0], "R8 next burst follows", q, b[W-1:0]);
      repeat (5) step_phase();
      chk(q_oe == 0, "R8 idle after pair", W'(q_oe), 0);

      // fallback to the input pair
      in_ck = out_ck; in_ckb = out_ckb;
      out_ck = 1'b1; out_ckb = 1'b1; fallback = 1'b1;
      repeat (2) @(negedge clk);
      a = mk(6);
      issue(a, 1'b1);
      step_phase();
      chk(q_oe == 1 && q == a[W-1:0] && echo_p == 1, "R9 input pair paces burst", q, a[W-1:0]);
      repeat (5) step_phase();
      chk(expq.size() == 0, "R9 all beats out", W'(expq.size()), 0);
      chk(q_oe == 0 && q_oe_d == 0, "R10 both builds idle", W'({q_oe, q_oe_d}), 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #800000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule